// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block is a serial master for a byte-organised EEPROM that is reached over a three-wire link: chip select, serial clock and serial data out, plus one serial data line coming back. A host hands it one operation at a time: an operation code, a 7-bit cell address and a data byte, together with a single-cycle request. The controller frames the matching 10-bit command and shifts any write data out after it. For reads it shifts in the returned byte. It then answers with a one-cycle acknowledge that carries a status code and, for reads, the byte.

For programming operations (byte write, byte erase and the two whole-array commands), the controller does the ready/busy handshake with the memory itself. It drops chip select for a minimum gap, raises it again, and watches the returning data line until the memory signals ready or a timeout expires. The two whole-array commands are only allowed while a configuration input permits them. Otherwise they are answered as unsupported without touching the wires. All timing is counted in system clocks derived from the `CLK_HZ` parameter. The serial clock runs at a programmable divide of the system clock.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: Each frame begins with a 10-bit command word sent most significant bit first, one bit per serial clock, as {1'b1, 2-bit opcode, 7-bit address}. The encodings are read = 0x300|a, write = 0x280|a, erase = 0x380|a, with a = `addr`. The `op` encodings are read=0, write=1, erase=2.
- R2: Commands that reuse the address field carry fixed words: write-enable (op=3) sends 0x260, write-disable (op=4) sends 0x200, erase-all (op=5) sends 0x240 and write-all (op=6) sends 0x220.
- R3: A read frame has 18 serial clocks (10 command plus 8 input). Write and write-all frames have 18 serial clocks, and the 8 after the command carry `wdata` MSB first. All other frames have exactly 10.
- R4: The serial clock idles low. `cs` stays high for the whole frame. `sclk` is never high while `cs` is low. `mosi` changes only while `sclk` is low, so the memory samples it on the rising edge.
- R5: During a read, bit k (k = 0..7, MSB first) of the returned byte is sampled from `miso` at the end of the high half of the (10+k)-th serial clock, half a period after its rising edge. The byte appears on `rdata` with status OK.
- R6: After a write, erase, erase-all or write-all frame, `cs` is held low for exactly CS_LOW_CYC = ceil(CS_LOW_NS·CLK_HZ/1e9) system clocks. It is then raised, and the controller polls `miso`. When `miso` reads 1 the operation is acknowledged OK.
- R7: If `miso` does not read 1 within TIMEOUT_CYC = TIMEOUT_US·CLK_HZ/1e6 clocks of `cs` being raised for the poll, the operation is acknowledged with status TIMEOUT, and `cs` returns low.
- R8: Erase-all and write-all with `bulk_en`=0 are acknowledged with status NOT_SUPPORTED one cycle after the request, and no frame is sent. The reserved op=7 is answered the same way.
- R9: Every accepted request produces exactly one `ack` pulse, one cycle wide. The status codes are OK=0, TIMEOUT=1 and NOT_SUPPORTED=2, and `rdata` is 0 for any operation other than a read.
- R10: A request raised while an operation is in progress is ignored. It causes no extra frame and no extra acknowledge.
- R11: After reset `cs`, `sclk`, `mosi` and `ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start an operation (sampled while idle) |
| op | input | 3 | Operation code |
| addr | input | 7 | Cell address |
| wdata | input | 8 | Byte for write and write-all |
| bulk_en | input | 1 | Permits erase-all and write-all |
| ack | output | 1 | One-cycle completion pulse |
| status | output | 2 | Completion status, valid with ack |
| rdata | output | 8 | Byte read, valid with ack |
| cs | output | 1 | Active-high chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to memory |
| miso | input | 1 | Serial data and ready level from memory |

## Verification
The case hardest to reach from the ports is the busy-poll timeout. A correct memory always becomes ready, so the bench's responder has a switch that keeps the returning line low forever. With the switch set, a write and an erase are run so that the length of the poll window is measured against TIMEOUT_CYC. A second hard case is a request that arrives in the middle of a frame. The bench injects one partway through a command, then counts frames and acknowledges over a quiet interval afterwards.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_WREN  = 3'd3,
        OP_WRDIS = 3'd4,
        OP_ERALL = 3'd5,
        OP_WRALL = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_TIMEOUT = 2'd1,
        ST_NOSUP   = 2'd2
    } status_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SHIFT = 2'd1,
        S_GAP   = 2'd2,
        S_POLL  = 2'd3
    } fsm_e;

    localparam int CMD_W   = 10;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = CMD_W + DATA_W;

    typedef struct packed {
        logic [CMD_W-1:0] word;
        logic             legal;
        logic             bulk;
        logic             has_wdata;
        logic             is_read;
        logic             is_prog;
    } cmd_t;

endpackage

// File: rtl/mw_cmd_build.sv
module mw_cmd_build
    import mw_pkg::*;
(
    input  logic [2:0] op,
    input  logic [6:0] addr,
    output cmd_t       cmd
);
    always_comb begin
        cmd       = '0;
        cmd.legal = 1'b1;
        case (op_e'(op))
            OP_READ:  begin cmd.word = 10'h300 | {3'b000, addr}; cmd.is_read = 1'b1; end
            OP_WRITE: begin cmd.word = 10'h280 | {3'b000, addr}; cmd.has_wdata = 1'b1; cmd.is_prog = 1'b1; end
            OP_ERASE: begin cmd.word = 10'h380 | {3'b000, addr}; cmd.is_prog = 1'b1; end
            OP_WREN:  cmd.word = 10'h260;
            OP_WRDIS: cmd.word = 10'h200;
            OP_ERALL: begin cmd.word = 10'h240; cmd.bulk = 1'b1; cmd.is_prog = 1'b1; end
            OP_WRALL: begin cmd.word = 10'h220; cmd.bulk = 1'b1; cmd.has_wdata = 1'b1; cmd.is_prog = 1'b1; end
            default:  cmd.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load)
            count_d = load_val;
        else if (count_q != '0)
            count_d = count_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign expired = (count_q == '0);
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
    import mw_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int SCK_HALF   = 25,
    parameter int CS_LOW_NS  = 250,
    parameter int TIMEOUT_US = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [2:0] op,
    input  logic [6:0] addr,
    input  logic [7:0] wdata,
    input  logic       bulk_en,
    output logic       ack,
    output logic [1:0] status,
    output logic [7:0] rdata,
    output logic       cs,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam longint GAP_L   = (longint'(CS_LOW_NS) * CLK_HZ + 64'd999_999_999) / 64'd1_000_000_000;
    localparam int     CS_LOW_CYC  = (GAP_L < 1) ? 1 : int'(GAP_L);
    localparam longint TMO_L   = (longint'(TIMEOUT_US) * CLK_HZ) / 64'd1_000_000;
    localparam int     TIMEOUT_CYC = (TMO_L < 1) ? 1 : int'(TMO_L);
    localparam int     TMR_MAX = (TIMEOUT_CYC > CS_LOW_CYC) ? TIMEOUT_CYC : CS_LOW_CYC;
    localparam int     TMR_W   = $clog2(TMR_MAX + 1);
    localparam int     HALF_W  = $clog2(SCK_HALF + 1);
    localparam logic [HALF_W-1:0] HALF_LOAD = HALF_W'(SCK_HALF - 1);

    typedef struct packed {
        fsm_e               fsm;
        logic               cs;
        logic               sclk;
        logic               mosi;
        logic [HALF_W-1:0]  half;
        logic [4:0]         bitn;
        logic [4:0]         last;
        logic [FRAME_W-1:0] sh;
        logic [7:0]         rx;
        logic               rd;
        logic               prog;
        logic               ack;
        logic [1:0]         status;
        logic [7:0]         rdata;
    } state_t;

    state_t            d, q;
    cmd_t              cmd;
    logic              tm_load, tm_exp;
    logic [TMR_W-1:0]  tm_val;
    logic [7:0]        rx_n;

    mw_cmd_build u_cmd (.op(op), .addr(addr), .cmd(cmd));

    mw_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .expired(tm_exp)
    );

    always_comb begin
        d       = q;
        d.ack   = 1'b0;
        tm_load = 1'b0;
        tm_val  = '0;
        rx_n    = q.rx;
        case (q.fsm)
            S_IDLE: if (req) begin
                if (!cmd.legal || (cmd.bulk && !bulk_en)) begin
                    d.ack    = 1'b1;
                    d.status = ST_NOSUP;
                    d.rdata  = '0;
                end else begin
                    d.fsm  = S_SHIFT;
                    d.cs   = 1'b1;
                    d.sclk = 1'b0;
                    d.sh   = {cmd.word, (cmd.has_wdata ? wdata : 8'h00)};
                    d.mosi = cmd.word[CMD_W-1];
                    d.half = HALF_LOAD;
                    d.bitn = '0;
                    d.last = (cmd.has_wdata || cmd.is_read) ? 5'(FRAME_W - 1) : 5'(CMD_W - 1);
                    d.rd   = cmd.is_read;
                    d.prog = cmd.is_prog;
                    d.rx   = '0;
                end
            end
            S_SHIFT: begin
                if (q.half != '0) begin
                    d.half = q.half - 1'b1;
                end else if (!q.sclk) begin
                    d.sclk = 1'b1;
                    d.half = HALF_LOAD;
                end else begin
                    d.sclk = 1'b0;
                    d.half = HALF_LOAD;
                    if (q.rd && q.bitn >= 5'(CMD_W))
                        rx_n = {q.rx[6:0], miso};
                    d.rx = rx_n;
                    if (q.bitn == q.last) begin
                        d.mosi = 1'b0;
                        d.cs   = 1'b0;
                        if (q.prog) begin
                            d.fsm   = S_GAP;
                            tm_load = 1'b1;
                            tm_val  = TMR_W'(CS_LOW_CYC - 1);
                        end else begin
                            d.fsm    = S_IDLE;
                            d.ack    = 1'b1;
                            d.status = ST_OK;
                            d.rdata  = q.rd ? rx_n : 8'h00;
                        end
                    end else begin
                        d.bitn = q.bitn + 5'd1;
                        d.sh   = {q.sh[FRAME_W-2:0], 1'b0};
                        d.mosi = q.sh[FRAME_W-2];
                    end
                end
            end
            S_GAP: if (tm_exp) begin
                d.cs    = 1'b1;
                d.fsm   = S_POLL;
                tm_load = 1'b1;
                tm_val  = TMR_W'(TIMEOUT_CYC - 1);
            end
            S_POLL: if (miso || tm_exp) begin
                d.cs     = 1'b0;
                d.fsm    = S_IDLE;
                d.ack    = 1'b1;
                d.status = miso ? ST_OK : ST_TIMEOUT;
                d.rdata  = '0;
            end
            default: d.fsm = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ack    = q.ack;
    assign status = q.status;
    assign rdata  = q.rdata;
    assign cs     = q.cs;
    assign sclk   = q.sclk;
    assign mosi   = q.mosi;
endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
module mw_eeprom_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ack,
    input logic [1:0] status,
    input logic       cs,
    input logic       sclk,
    input logic       mosi
);
    // R4: clock never high outside a frame
    p_sclk_low_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !sclk);

    // R4: data held while the clock is high
    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R9: acknowledge is a single-cycle pulse
    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R9: only defined status codes
    p_status_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (status != 2'd3));

    // R7: every completion leaves the bus idle
    p_ack_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (!cs && !sclk));

    // R8: refused request never opened a frame
    p_nosup_noframe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && status == 2'd2) |-> (!cs && !$past(cs)));
endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .status(status),
    .cs(cs), .sclk(sclk), .mosi(mosi)
);

// File: tb/sim_mw_eeprom_ctrl.sv
module sim_mw_eeprom_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 4_000_000;
    localparam int SCK_HALF   = 2;
    localparam int CS_LOW_NS  = 1000;
    localparam int TIMEOUT_US = 5000;
    localparam int EXP_GAP    = (CS_LOW_NS * (CLK_HZ / 1_000_000) + 999) / 1000;
    localparam int EXP_TMO    = TIMEOUT_US * (CLK_HZ / 1_000_000);
    localparam int BUSY_CYC   = 30;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       req = 1'b0, bulk_i = 1'b0, miso = 1'b0;
    logic [2:0] op_i = '0;
    logic [6:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic       ack, cs, sclk, mosi;
    logic [1:0] status;
    logic [7:0] rdata;

    int n_cmp = 0, n_bad = 0;

    mw_eeprom_ctrl #(.CLK_HZ(CLK_HZ), .SCK_HALF(SCK_HALF), .CS_LOW_NS(CS_LOW_NS),
                     .TIMEOUT_US(TIMEOUT_US)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op_i), .addr(addr_i), .wdata(wdata_i),
        .bulk_en(bulk_i), .ack(ack), .status(status), .rdata(rdata),
        .cs(cs), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // responder / monitor state
    logic [7:0]  mem [128];
    logic        cs_prev = 0, sclk_prev = 0, mosi_prev = 0, hang = 0;
    logic [17:0] fword = '0;
    logic [9:0]  cmd_w = '0, last_cmd = '0;
    logic [7:0]  last_data = '0;
    int fbits = 0, last_nbits = 0, busy_left = 0;
    int hi_cnt = 0, lo_cnt = 0, gap_meas = 0, last_poll = 0;
    int n_frames = 0, n_acks = 0, n_viol = 0;

    function automatic logic is_rd_data();
        return cs && fbits >= 10 && cmd_w[9:7] == 3'b110;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (ack) n_acks++;
            if (busy_left > 0) busy_left--;
            if (sclk && !cs) n_viol++;
            if (sclk && sclk_prev && mosi != mosi_prev) n_viol++;
            if (cs && !cs_prev) begin
                fbits = 0; fword = '0; cmd_w = '0; hi_cnt = 0; gap_meas = lo_cnt;
            end
            if (!cs && cs_prev) begin
                if (fbits > 0) begin
                    n_frames++;
                    last_cmd = cmd_w; last_nbits = fbits; last_data = fword[7:0];
                    if (cmd_w[9:7] == 3'b101 && fbits == 18) begin
                        mem[cmd_w[6:0]] = fword[7:0]; busy_left = BUSY_CYC;
                    end else if (cmd_w[9:7] == 3'b111) begin
                        mem[cmd_w[6:0]] = 8'hFF; busy_left = BUSY_CYC;
                    end else if (cmd_w == 10'h240) begin
                        for (int i = 0; i < 128; i++) mem[i] = 8'hFF;
                        busy_left = BUSY_CYC;
                    end else if (cmd_w == 10'h220 && fbits == 18) begin
                        for (int i = 0; i < 128; i++) mem[i] = fword[7:0];
                        busy_left = BUSY_CYC;
                    end
                end else begin
                    last_poll = hi_cnt;
                end
                lo_cnt = 0;
            end
            if (cs) hi_cnt++; else lo_cnt++;
            if (cs && sclk && !sclk_prev) begin
                if (is_rd_data()) miso = mem[cmd_w[6:0]][7 - (fbits - 10)];
                fword = {fword[16:0], mosi};
                fbits++;
                if (fbits == 10) cmd_w = fword[9:0];
            end
            if (!is_rd_data()) miso = (busy_left == 0) && !hang;
        end
        cs_prev = cs; sclk_prev = sclk; mosi_prev = mosi;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_word(input logic [2:0] op, input logic [6:0] a);
        case (op)
            3'd0: return 32'h300 | a;
            3'd1: return 32'h280 | a;
            3'd2: return 32'h380 | a;
            3'd3: return 32'h260;
            3'd4: return 32'h200;
            3'd5: return 32'h240;
            default: return 32'h220;
        endcase
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [6:0] a, input logic [7:0] wd,
                          input logic be, input logic poke);
        int fr0 = n_frames, ak0 = n_acks, k = 0;
        logic got = 0, nosup, prog;
        logic [1:0] st = '0;
        logic [7:0] rd = '0, exp_rd;
        exp_rd = mem[a];
        nosup = (op == 3'd7) || ((op == 3'd5 || op == 3'd6) && !be);
        prog  = (op == 3'd1 || op == 3'd2 || op == 3'd5 || op == 3'd6);
        op_i = op; addr_i = a; wdata_i = wd; bulk_i = be;
        req = 1'b1;
        while (!got && k < 60000) begin
            @(negedge clk);
            if (k == 0) req = 1'b0;
            if (poke && k == 20) begin req = 1'b1; op_i = 3'd0; addr_i = a ^ 7'h1; end
            if (poke && k == 21) req = 1'b0;
            if (ack) begin got = 1; st = status; rd = rdata; end
            k++;
        end
        repeat (poke ? 40 : 3) @(negedge clk);
        chk("R9 single ack", n_acks, ak0 + 1);
        if (nosup) begin
            chk("R8 status not-supported", st, 2);
            chk("R8 no frame sent", n_frames, fr0);
        end else begin
            chk("R10 exactly one frame", n_frames, fr0 + 1);
            if (op <= 3'd2) chk("R1 command word", last_cmd, exp_word(op, a));
            else            chk("R2 command word", last_cmd, exp_word(op, a));
            chk("R3 clock count", last_nbits, (op == 3'd0 || op == 3'd1 || op == 3'd6) ? 18 : 10);
            if (op == 3'd1 || op == 3'd6) chk("R3 data byte", last_data, wd);
            if (op == 3'd0) chk("R5 read byte", rd, exp_rd);
            else            chk("R9 rdata zero", rd, 0);
            if (prog) chk("R6 chip-select gap", gap_meas, EXP_GAP);
            if (prog && hang) begin
                chk("R7 timeout status", st, 1);
                chk("R7 poll window", last_poll, EXP_TMO);
            end else begin
                chk("R6 status ok", st, 0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 128; i++) mem[i] = 8'(i * 3 + 1);
        repeat (4) @(negedge clk);
        chk("R11 reset cs", cs, 0);
        chk("R11 reset sclk", sclk, 0);
        chk("R11 reset mosi", mosi, 0);
        chk("R11 reset ack", ack, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_op(3'd3, 7'h00, 8'h00, 1'b0, 1'b0);
        run_op(3'd1, 7'h05, 8'hA5, 1'b0, 1'b1);
        run_op(3'd0, 7'h05, 8'h00, 1'b0, 1'b1);
        run_op(3'd2, 7'h05, 8'h00, 1'b0, 1'b0);
        run_op(3'd0, 7'h05, 8'h00, 1'b0, 1'b0);
        run_op(3'd0, 7'h7F, 8'h00, 1'b0, 1'b0);
        run_op(3'd5, 7'h00, 8'h00, 1'b0, 1'b0);
        run_op(3'd6, 7'h00, 8'h5A, 1'b0, 1'b0);
        run_op(3'd7, 7'h11, 8'h00, 1'b1, 1'b0);
        run_op(3'd6, 7'h00, 8'h3C, 1'b1, 1'b0);
        run_op(3'd0, 7'h42, 8'h00, 1'b0, 1'b0);
        run_op(3'd5, 7'h00, 8'h00, 1'b1, 1'b0);
        run_op(3'd4, 7'h00, 8'h00, 1'b0, 1'b0);

        hang = 1'b1;
        run_op(3'd1, 7'h10, 8'h77, 1'b0, 1'b0);
        run_op(3'd2, 7'h11, 8'h00, 1'b0, 1'b0);
        hang = 1'b0;
        repeat (3) @(negedge clk);

        for (int i = 0; i < 60; i++) begin
            run_op(3'($urandom % 8), 7'($urandom), 8'($urandom), 1'($urandom), 1'b0);
        end

        chk("R4 mode-0 violations", n_viol, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule